// File: doc/BRIEF.md
# Single-Source Fast Interrupt Selector

This block picks one interrupt source out of seventy-two level inputs and forwards its level to a dedicated fast-interrupt line. The inputs arrive as three banks: bank 0 with 8 sources, and banks 1 and 2 with 32 sources each. One 8-bit control register chooses the source and gates the line. Software writes the register through a simple word-write port and can read it back.

The source is chosen by a flat 7-bit index. This index does not follow numeric bank order. Bank 1 comes first, then bank 2, then the eight bank-0 sources. The output is the enable bit ANDed with the selected raw level, and it is registered once on the clock.

A source routed here still raises its normal interrupt if that path also has it enabled, so both lines would assert together. To make this visible, the block takes the per-source normal-path enables and drives a registered overlap flag.

Top module: `fiqsel_top`

## Requirements
- R1: After reset, the control register reads 0x00000000, and `fiq_o` and `overlap_o` are low.
- R2: A write with address 0x0C stores `cfg_wdata_i[7:0]`. Bits 6:0 are the source index and bit 7 is the enable. A read at 0x0C returns the stored byte in bits 7:0, and bits 31:8 always read zero whatever was written there.
- R3: A write to any address other than 0x0C leaves the register unchanged. A read at any other address returns zero.
- R4: Index values 0 to 31 select bank-1 source number (index).
- R5: Index values 32 to 63 select bank-2 source number (index − 32).
- R6: Index values 64 to 71 select bank-0 source number (index − 64).
- R7: Index values 72 to 127 select no source, and `fiq_o` stays low even when every input is high.
- R8: While the enable bit is 0, `fiq_o` is low whatever the source levels are.
- R9: `fiq_o` follows the enable AND the selected level with exactly one clock of delay. It takes effect one clock after a register write or a source change.
- R10: `overlap_o` is high, one clock later, exactly when three things hold together: the enable is set, the selected source is high, and that same source's normal-path enable is high.
- R11: Sources other than the selected one have no effect on `fiq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Byte address of the access |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for `cfg_addr_i` (combinational) |
| bank0_src_i | input | 8 | Bank-0 raw interrupt levels |
| bank1_src_i | input | 32 | Bank-1 raw interrupt levels |
| bank2_src_i | input | 32 | Bank-2 raw interrupt levels |
| bank0_irq_en_i | input | 8 | Bank-0 normal-path enables |
| bank1_irq_en_i | input | 32 | Bank-1 normal-path enables |
| bank2_irq_en_i | input | 32 | Bank-2 normal-path enables |
| fiq_o | output | 1 | Registered fast-interrupt line |
| overlap_o | output | 1 | Registered flag: the routed source is also enabled on the normal path |

## Verification
Each bank is tested in two ways: with only the selected bit high, and with every bit high except the selected one. The first shows that the index reaches the right bit in the 1-2-0 bank order. The second shows that no neighbouring bit leaks onto the line. Indices at the bank edges (0, 31, 32, 63, 64, 71) catch off-by-one offsets. Indices 72, 100 and 127 with all inputs high separate "no source" from a wrapped decode. A source toggled against a disabled register, and a single-clock latency probe, separate gating from timing. The overlap flag is driven with the normal-path enable on the routed source, then on a different source, then with FIQ disabled.

// File: rtl/fiqsel_pkg.sv
package fiqsel_pkg;

    localparam int B0_N      = 8;
    localparam int B1_N      = 32;
    localparam int B2_N      = 32;
    localparam int TOTAL_N   = B1_N + B2_N + B0_N;
    localparam int IDX_W     = $clog2(TOTAL_N);
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam logic [ADDR_W-1:0] CTRL_OFFSET = 8'h0C;

    // Flat index bases: bank 1 first, then bank 2, then bank 0.
    localparam int B1_BASE   = 0;
    localparam int B2_BASE   = B1_BASE + B1_N;
    localparam int B0_BASE   = B2_BASE + B2_N;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/fiqsel_ctrl_reg.sv
module fiqsel_ctrl_reg
    import fiqsel_pkg::*;
#(
    parameter int                 P_ADDR_W = ADDR_W,
    parameter int                 P_DATA_W = DATA_W,
    parameter logic [P_ADDR_W-1:0] P_OFFSET = CTRL_OFFSET
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [P_ADDR_W-1:0] addr_i,
    input  logic [P_DATA_W-1:0] wdata_i,
    output ctrl_t               ctrl_o,
    output logic [P_DATA_W-1:0] rdata_o
);

    localparam int PAD_W = P_DATA_W - CTRL_W;

    typedef struct packed {
        ctrl_t ctrl;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        hit  = (addr_i == P_OFFSET);
        st_d = st_q;
        if (we_i && hit) begin
            st_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit) begin
            rdata_o = {{PAD_W{1'b0}}, st_q.ctrl};
        end
    end

    assign ctrl_o = st_q.ctrl;

    AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (addr_i != P_OFFSET)) |=> $stable(ctrl_o)); // R3

    AST_WRITE_LOW_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (addr_i == P_OFFSET) && (wdata_i[P_DATA_W-1:CTRL_W] != '0))
        |=> (ctrl_o == $past(wdata_i[CTRL_W-1:0]))); // R2

endmodule

// File: rtl/fiqsel_src_mux.sv
module fiqsel_src_mux
    import fiqsel_pkg::*;
#(
    parameter int P_B0_N = B0_N,
    parameter int P_B1_N = B1_N,
    parameter int P_B2_N = B2_N
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [P_B0_N-1:0] b0_src_i,
    input  logic [P_B1_N-1:0] b1_src_i,
    input  logic [P_B2_N-1:0] b2_src_i,
    input  logic [P_B0_N-1:0] b0_en_i,
    input  logic [P_B1_N-1:0] b1_en_i,
    input  logic [P_B2_N-1:0] b2_en_i,
    output logic              valid_o,
    output logic              sel_src_o,
    output logic              sel_en_o
);

    localparam int N     = P_B1_N + P_B2_N + P_B0_N;
    localparam int BASE2 = P_B1_N;
    localparam int BASE0 = P_B1_N + P_B2_N;

    logic [N-1:0] flat_src;
    logic [N-1:0] flat_en;
    logic [N-1:0] dec;

    // Flatten in the selector's order: bank 1, bank 2, bank 0.
    for (genvar i = 0; i < N; i++) begin : g_flat
        if (i < BASE2) begin : g_b1
            assign flat_src[i] = b1_src_i[i];
            assign flat_en[i]  = b1_en_i[i];
        end else if (i < BASE0) begin : g_b2
            assign flat_src[i] = b2_src_i[i-BASE2];
            assign flat_en[i]  = b2_en_i[i-BASE2];
        end else begin : g_b0
            assign flat_src[i] = b0_src_i[i-BASE0];
            assign flat_en[i]  = b0_en_i[i-BASE0];
        end
        assign dec[i] = (idx_i == IDX_W'(i));
    end

    always_comb begin
        valid_o   = (|dec);
        sel_src_o = (|(dec & flat_src));
        sel_en_o  = (|(dec & flat_en));
    end

endmodule

// File: rtl/fiqsel_gate.sv
module fiqsel_gate
    import fiqsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl_i,
    input  logic  valid_i,
    input  logic  sel_src_i,
    input  logic  sel_en_i,
    output logic  fiq_o,
    output logic  overlap_o
);

    typedef struct packed {
        logic fiq;
        logic ovl;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.fiq = ctrl_i.en & valid_i & sel_src_i;
        st_d.ovl = ctrl_i.en & valid_i & sel_src_i & sel_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fiq_o     = st_q.fiq;
    assign overlap_o = st_q.ovl;

    AST_FIQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(ctrl_i.en)); // R8

    AST_FIQ_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> ($past(ctrl_i.idx) < IDX_W'(TOTAL_N))); // R7

    AST_OVERLAP_NEEDS_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_o |-> fiq_o); // R10

endmodule

// File: rtl/fiqsel_top.sv
module fiqsel_top
    import fiqsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    input  logic [B0_N-1:0]   bank0_src_i,
    input  logic [B1_N-1:0]   bank1_src_i,
    input  logic [B2_N-1:0]   bank2_src_i,
    input  logic [B0_N-1:0]   bank0_irq_en_i,
    input  logic [B1_N-1:0]   bank1_irq_en_i,
    input  logic [B2_N-1:0]   bank2_irq_en_i,
    output logic              fiq_o,
    output logic              overlap_o
);

    ctrl_t ctrl;
    logic  sel_valid;
    logic  sel_src;
    logic  sel_en;

    fiqsel_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .ctrl_o  (ctrl),
        .rdata_o (cfg_rdata_o)
    );

    fiqsel_src_mux u_mux (
        .idx_i     (ctrl.idx),
        .b0_src_i  (bank0_src_i),
        .b1_src_i  (bank1_src_i),
        .b2_src_i  (bank2_src_i),
        .b0_en_i   (bank0_irq_en_i),
        .b1_en_i   (bank1_irq_en_i),
        .b2_en_i   (bank2_irq_en_i),
        .valid_o   (sel_valid),
        .sel_src_o (sel_src),
        .sel_en_o  (sel_en)
    );

    fiqsel_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_i    (ctrl),
        .valid_i   (sel_valid),
        .sel_src_i (sel_src),
        .sel_en_i  (sel_en),
        .fiq_o     (fiq_o),
        .overlap_o (overlap_o)
    );

endmodule

// File: tb/tb_fiqsel_top.sv
module tb_fiqsel_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h0C;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  b0 = '0, e0 = '0;
    logic [31:0] b1 = '0, b2 = '0, e1 = '0, e2 = '0;
    logic        fiq, ovl;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fiqsel_top dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
        .bank0_src_i(b0), .bank1_src_i(b1), .bank2_src_i(b2),
        .bank0_irq_en_i(e0), .bank1_irq_en_i(e1), .bank2_irq_en_i(e2),
        .fiq_o(fiq), .overlap_o(ovl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick();
        we = 1'b0; addr = 8'h0C;
        tick();
    endtask

    task automatic clear_inputs;
        b0 = '0; b1 = '0; b2 = '0; e0 = '0; e1 = '0; e2 = '0;
    endtask

    task automatic set_src(input int idx, input logic v);
        if (idx < 32)      b1[idx] = v;
        else if (idx < 64) b2[idx-32] = v;
        else if (idx < 72) b0[idx-64] = v;
    endtask

    task automatic t_reset;
        addr = 8'h0C;
        #1;
        chk("R1 reg", rdata, 32'h0);
        chk("R1 fiq", {31'b0, fiq}, 32'h0);
        chk("R1 overlap", {31'b0, ovl}, 32'h0);
    endtask

    task automatic t_regrw;
        wr(8'h0C, 32'hA5A5_5A23);
        chk("R2 readback", rdata, 32'h0000_0023);
        wr(8'h0C, 32'hFFFF_FF80);
        chk("R2 upper zero", rdata, 32'h0000_0080);
    endtask

    task automatic t_offset;
        wr(8'h0C, 32'h0000_0011);
        wr(8'h10, 32'h0000_0085);
        wr(8'h08, 32'h0000_00C0);
        addr = 8'h0C; #1;
        chk("R3 reg kept", rdata, 32'h0000_0011);
        addr = 8'h10; #1;
        chk("R3 other read", rdata, 32'h0);
        addr = 8'h0C;
    endtask

    // Single-bit and all-but-one patterns for one index.
    task automatic t_index(input string tag, input int idx);
        clear_inputs();
        wr(8'h0C, 32'h80 | idx);
        set_src(idx, 1'b1);
        tick();
        chk({tag, " selected high"}, {31'b0, fiq}, 32'h1);
        b0 = '1; b1 = '1; b2 = '1;
        set_src(idx, 1'b0);
        tick();
        chk({tag, " R11 others high"}, {31'b0, fiq}, 32'h0);
        clear_inputs();
    endtask

    task automatic t_nosel(input int idx);
        clear_inputs();
        wr(8'h0C, 32'h80 | idx);
        b0 = '1; b1 = '1; b2 = '1;
        tick();
        chk($sformatf("R7 idx %0d", idx), {31'b0, fiq}, 32'h0);
        clear_inputs();
    endtask

    task automatic t_disable;
        clear_inputs();
        wr(8'h0C, 32'h05);
        b1[5] = 1'b1;
        tick(); tick();
        chk("R8 disabled", {31'b0, fiq}, 32'h0);
        wr(8'h0C, 32'h85);
        chk("R8 enabled", {31'b0, fiq}, 32'h1);
        clear_inputs();
    endtask

    task automatic t_latency;
        clear_inputs();
        wr(8'h0C, 32'h80 | 66);
        tick();
        b0[2] = 1'b1;
        #1;
        chk("R9 before edge", {31'b0, fiq}, 32'h0);
        tick();
        chk("R9 after edge", {31'b0, fiq}, 32'h1);
        b0[2] = 1'b0;
        #1;
        chk("R9 hold", {31'b0, fiq}, 32'h1);
        tick();
        chk("R9 drop", {31'b0, fiq}, 32'h0);
        // Register write: effect exactly one clock after the write edge.
        b1[3] = 1'b1;
        we = 1'b1; addr = 8'h0C; wdata = 32'h83;
        tick();
        we = 1'b0;
        chk("R9 write no early", {31'b0, fiq}, 32'h0);
        tick();
        chk("R9 write effect", {31'b0, fiq}, 32'h1);
        clear_inputs();
    endtask

    task automatic t_overlap;
        clear_inputs();
        wr(8'h0C, 32'h80 | 40);
        b2[8] = 1'b1;
        e2[8] = 1'b1;
        tick();
        chk("R10 overlap set", {31'b0, ovl}, 32'h1);
        e2[8] = 1'b0;
        e2[9] = 1'b1;
        e1 = '1; e0 = '1;
        tick();
        chk("R10 other enable", {31'b0, ovl}, 32'h0);
        chk("R10 fiq still", {31'b0, fiq}, 32'h1);
        e2[8] = 1'b1;
        wr(8'h0C, 32'd40);
        chk("R10 fiq disabled", {31'b0, ovl}, 32'h0);
        clear_inputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_regrw();
        t_offset();
        t_index("R4 idx0", 0);
        t_index("R4 idx17", 17);
        t_index("R4 idx31", 31);
        t_index("R5 idx32", 32);
        t_index("R5 idx50", 50);
        t_index("R5 idx63", 63);
        t_index("R6 idx64", 64);
        t_index("R6 idx69", 69);
        t_index("R6 idx71", 71);
        t_nosel(72);
        t_nosel(100);
        t_nosel(127);
        t_disable();
        t_latency();
        t_overlap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule